// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block collects up to eight active-low, level-sensitive interrupt request lines for a small 8-bit sequencer and keeps three software-visible control registers: a pending bank, a per-line enable mask and one global enable flag. Software reads and writes them by index through a plain register port. A request line held low sets its pending bit, which stays set until software writes a 1 to that bit.

When some line is both pending and unmasked, the global flag is on and no handler is already running, the unit raises a request towards the sequencer and reports the lowest-numbered eligible line. Every line shares one vector. When the sequencer accepts, the unit emits a one-cycle push of the return address and the carry and zero flags and asks for a jump to the vector. No further request is raised until the interrupt-return handshake has popped the saved address and flags, which the unit then hands back for restore. The stack storage, decode and datapath sit outside.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset the pending (index 0), mask (index 1) and global enable (index 2) registers all read 0 and `irq_req_o` is 0.
- R2: A request line held low sets its pending bit SYNC_STAGES+1 rising edges after it is first sampled low; the bit stays set after the line returns high.
- R3: Writing index 0 clears each pending bit whose data bit is 1, and bits written 0 keep their value; a cleared bit whose line is still low reads 1 again one clock after the write.
- R4: Register index 2 holds the global enable in data bit 0 and reads 0 in bits 7..1; index 3 reads 0.
- R5: `irq_req_o` is 1 only when some bit is set in both pending and mask and the global enable is 1; with the global enable at 0 no request is raised whatever the mask.
- R6: While `irq_req_o` is 1, `src_id_o` is the lowest bit number set in pending AND mask.
- R7: In a cycle with `irq_req_o` and `take_i` both 1, `push_o` and `vec_load_o` are 1, `push_addr_o` equals `next_pc_i`, the pushed carry and zero equal `carry_i` and `zero_i`, and `vector_o` equals VEC_ADDR (default 0).
- R8: From the cycle after a push until the return completes, `irq_req_o` stays 0 even with an eligible pending line.
- R9: `iret_i` during service gives `pop_o` in the same cycle; the cycle after `pop_valid_i`, `restore_o` is 1 with the popped address, carry and zero; `iret_i` outside service gives no `pop_o`.
- R10: Pending and mask bits at or above NUM_IRQ read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n_i | input | NUM_IRQ | Interrupt request lines, active low, level sensitive |
| reg_sel_i | input | 2 | Register index: 0 pending, 1 mask, 2 global enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the indexed register |
| irq_req_o | output | 1 | Interrupt request to the sequencer |
| src_id_o | output | clog2(NUM_IRQ) | Lowest eligible line number |
| take_i | input | 1 | Sequencer accepts the request this cycle |
| next_pc_i | input | PC_W | Address of the next instruction |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| push_o | output | 1 | Push strobe to the return stack |
| push_addr_o | output | PC_W | Return address to push |
| push_carry_o | output | 1 | Carry flag to push |
| push_zero_o | output | 1 | Zero flag to push |
| vec_load_o | output | 1 | Load the program counter with the vector |
| vector_o | output | PC_W | Vector address |
| iret_i | input | 1 | Interrupt-return instruction executing |
| pop_o | output | 1 | Pop strobe to the return stack |
| pop_valid_i | input | 1 | Popped entry valid |
| pop_addr_i | input | PC_W | Popped return address |
| pop_carry_i | input | 1 | Popped carry flag |
| pop_zero_i | input | 1 | Popped zero flag |
| restore_o | output | 1 | Restore strobe to the sequencer |
| restore_addr_o | output | PC_W | Address to resume at |
| restore_carry_o | output | 1 | Carry flag to restore |
| restore_zero_o | output | 1 | Zero flag to restore |

## Verification
A pending bit that drops or sticks wrongly shows on the index-0 read in the very cycle after the offending edge, and it also moves `src_id_o` at once because the priority pick is combinational. A service state that leaves too early shows as `irq_req_o` rising during a handler within one clock of the push; one that never leaves shows as no request after `restore_o`. The bench sweeps every pending and every mask pattern of a six-line build, so each line, the lowest-bit priority and the unused upper bits are all seen at the read port.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   localparam int REG_W = 8;
   localparam int MAX_IRQ = 8;

   typedef enum logic [1:0] {
      IDX_PEND = 2'd0,
      IDX_MASK = 2'd1,
      IDX_GIE  = 2'd2,
      IDX_NONE = 2'd3
   } csr_idx_e;

   typedef enum logic [1:0] {
      SVC_IDLE = 2'd0,
      SVC_BUSY = 2'd1,
      SVC_POP  = 2'd2
   } svc_state_e;

   function automatic int src_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NUM_IRQ     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_n_i,
   input  logic [NUM_IRQ-1:0] clr_i,
   output logic [NUM_IRQ-1:0] pend_o
);

   logic [NUM_IRQ-1:0] req_s;
   logic [NUM_IRQ-1:0] pend_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign req_s = ~irq_n_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][NUM_IRQ-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= ~irq_n_i;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  chain_q[k] <= chain_q[k-1];
               end
            end
         end
         assign req_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // A write of 1 wins for one cycle; a line still low sets the bit again next edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= (pend_q | req_s) & ~clr_i;
      end
   end

   assign pend_o = pend_q;

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_i)) == '0)); // R3

endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
   parameter int NUM_IRQ = 8,
   parameter int ID_W    = 3
) (
   input  logic [NUM_IRQ-1:0] elig_i,
   output logic [ID_W-1:0]    id_o,
   output logic               any_o
);

   always_comb begin
      id_o = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (elig_i[i]) begin
            id_o = ID_W'(i);
         end
      end
   end

   assign any_o = |elig_i;

endmodule

// File: rtl/irq_svc_fsm.sv
module irq_svc_fsm
   import irq_ctl_pkg::*;
#(
   parameter int          PC_W     = 12,
   parameter logic [PC_W-1:0] VEC_ADDR = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cand_i,
   input  logic            take_i,
   input  logic [PC_W-1:0] next_pc_i,
   input  logic            carry_i,
   input  logic            zero_i,
   input  logic            iret_i,
   input  logic            pop_valid_i,
   input  logic [PC_W-1:0] pop_addr_i,
   input  logic            pop_carry_i,
   input  logic            pop_zero_i,
   output logic            irq_req_o,
   output logic            push_o,
   output logic [PC_W-1:0] push_addr_o,
   output logic            push_carry_o,
   output logic            push_zero_o,
   output logic            vec_load_o,
   output logic [PC_W-1:0] vector_o,
   output logic            pop_o,
   output logic            restore_o,
   output logic [PC_W-1:0] restore_addr_o,
   output logic            restore_carry_o,
   output logic            restore_zero_o
);

   svc_state_e      state_q;
   logic            fire;
   logic            rst_q;
   logic [PC_W-1:0] raddr_q;
   logic            rc_q;
   logic            rz_q;

   assign irq_req_o    = (state_q == SVC_IDLE) && cand_i;
   assign fire         = irq_req_o && take_i;
   assign push_o       = fire;
   assign vec_load_o   = fire;
   assign push_addr_o  = next_pc_i;
   assign push_carry_o = carry_i;
   assign push_zero_o  = zero_i;
   assign vector_o     = VEC_ADDR;
   assign pop_o        = (state_q == SVC_BUSY) && iret_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SVC_IDLE;
         rst_q   <= 1'b0;
         raddr_q <= '0;
         rc_q    <= 1'b0;
         rz_q    <= 1'b0;
      end else begin
         rst_q <= 1'b0;
         unique case (state_q)
            SVC_IDLE: if (fire) state_q <= SVC_BUSY;
            SVC_BUSY: if (iret_i) state_q <= SVC_POP;
            SVC_POP: begin
               if (pop_valid_i) begin
                  state_q <= SVC_IDLE;
                  rst_q   <= 1'b1;
                  raddr_q <= pop_addr_i;
                  rc_q    <= pop_carry_i;
                  rz_q    <= pop_zero_i;
               end
            end
            default: state_q <= SVC_IDLE;
         endcase
      end
   end

   assign restore_o       = rst_q;
   assign restore_addr_o  = raddr_q;
   assign restore_carry_o = rc_q;
   assign restore_zero_o  = rz_q;

   AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |=> !irq_req_o); // R8
   AST_RESTORE_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
      restore_o |-> $past(pop_valid_i)); // R9
   AST_RESTORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      restore_o |-> (restore_addr_o == $past(pop_addr_i))); // R9
   AST_POP_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pop_o |-> !irq_req_o); // R9

endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
   import irq_ctl_pkg::*;
#(
   parameter int              NUM_IRQ     = 8,
   parameter int              SYNC_STAGES = 2,
   parameter int              PC_W        = 12,
   parameter logic [PC_W-1:0] VEC_ADDR    = '0
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [NUM_IRQ-1:0]                      irq_n_i,
   input  logic [1:0]                              reg_sel_i,
   input  logic                                    reg_wr_i,
   input  logic [7:0]                              reg_wdata_i,
   output logic [7:0]                              reg_rdata_o,
   output logic                                    irq_req_o,
   output logic [irq_ctl_pkg::src_width(NUM_IRQ)-1:0] src_id_o,
   input  logic                                    take_i,
   input  logic [PC_W-1:0]                         next_pc_i,
   input  logic                                    carry_i,
   input  logic                                    zero_i,
   output logic                                    push_o,
   output logic [PC_W-1:0]                         push_addr_o,
   output logic                                    push_carry_o,
   output logic                                    push_zero_o,
   output logic                                    vec_load_o,
   output logic [PC_W-1:0]                         vector_o,
   input  logic                                    iret_i,
   output logic                                    pop_o,
   input  logic                                    pop_valid_i,
   input  logic [PC_W-1:0]                         pop_addr_i,
   input  logic                                    pop_carry_i,
   input  logic                                    pop_zero_i,
   output logic                                    restore_o,
   output logic [PC_W-1:0]                         restore_addr_o,
   output logic                                    restore_carry_o,
   output logic                                    restore_zero_o
);

   localparam int ID_W = src_width(NUM_IRQ);
   localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((1 << NUM_IRQ) - 1);

   generate
      if (NUM_IRQ < 1 || NUM_IRQ > MAX_IRQ) begin : g_bad_num
         $error("irq_ctl_unit: NUM_IRQ must lie in 1..8");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("irq_ctl_unit: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   csr_idx_e           sel;
   logic [NUM_IRQ-1:0] pend;
   logic [NUM_IRQ-1:0] mask_q;
   logic               gie_q;
   logic [NUM_IRQ-1:0] pend_clr;
   logic [NUM_IRQ-1:0] elig;
   logic               elig_any;

   assign sel      = csr_idx_e'(reg_sel_i);
   assign pend_clr = (reg_wr_i && sel == IDX_PEND) ? reg_wdata_i[NUM_IRQ-1:0] : '0;

   irq_pend_bank #(
      .NUM_IRQ     (NUM_IRQ),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_n_i (irq_n_i),
      .clr_i   (pend_clr),
      .pend_o  (pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         gie_q  <= 1'b0;
      end else if (reg_wr_i) begin
         if (sel == IDX_MASK) mask_q <= reg_wdata_i[NUM_IRQ-1:0];
         if (sel == IDX_GIE)  gie_q  <= reg_wdata_i[0];
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      unique case (sel)
         IDX_PEND: reg_rdata_o[NUM_IRQ-1:0] = pend;
         IDX_MASK: reg_rdata_o[NUM_IRQ-1:0] = mask_q;
         IDX_GIE:  reg_rdata_o[0]           = gie_q;
         default:  reg_rdata_o              = '0;
      endcase
   end

   assign elig = pend & mask_q;

   irq_pick_lowest #(
      .NUM_IRQ (NUM_IRQ),
      .ID_W    (ID_W)
   ) u_pick (
      .elig_i (elig),
      .id_o   (src_id_o),
      .any_o  (elig_any)
   );

   irq_svc_fsm #(
      .PC_W     (PC_W),
      .VEC_ADDR (VEC_ADDR)
   ) u_svc (
      .clk             (clk),
      .rst_n           (rst_n),
      .cand_i          (elig_any && gie_q),
      .take_i          (take_i),
      .next_pc_i       (next_pc_i),
      .carry_i         (carry_i),
      .zero_i          (zero_i),
      .iret_i          (iret_i),
      .pop_valid_i     (pop_valid_i),
      .pop_addr_i      (pop_addr_i),
      .pop_carry_i     (pop_carry_i),
      .pop_zero_i      (pop_zero_i),
      .irq_req_o       (irq_req_o),
      .push_o          (push_o),
      .push_addr_o     (push_addr_o),
      .push_carry_o    (push_carry_o),
      .push_zero_o     (push_zero_o),
      .vec_load_o      (vec_load_o),
      .vector_o        (vector_o),
      .pop_o           (pop_o),
      .restore_o       (restore_o),
      .restore_addr_o  (restore_addr_o),
      .restore_carry_o (restore_carry_o),
      .restore_zero_o  (restore_zero_o)
   );

   AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> gie_q); // R5
   AST_SRC_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> elig[src_id_o]); // R6
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == IDX_PEND || sel == IDX_MASK) |-> ((reg_rdata_o & ~IMPL_MASK) == '0)); // R10
   AST_GIE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == IDX_GIE) |-> (reg_rdata_o[7:1] == '0)); // R4

endmodule

// File: tb/irq_ctl_unit_test.sv
`timescale 1ns/1ps
module irq_ctl_unit_test;

   localparam int N    = 6;
   localparam int PCW  = 12;
   localparam int IDW  = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   irq_n = '1;
   logic [1:0]     sel = 2'd0;
   logic           wr = 1'b0;
   logic [7:0]     wdata = '0;
   logic [7:0]     rdata;
   logic           req;
   logic [IDW-1:0] src;
   logic           take = 1'b0;
   logic [PCW-1:0] npc = '0;
   logic           cin = 1'b0;
   logic           zin = 1'b0;
   logic           push, pc_o, pz_o, vload, pop, restore, rc_o, rz_o;
   logic [PCW-1:0] paddr, vec, raddr;
   logic           iret = 1'b0;
   logic           popv = 1'b0;
   logic [PCW-1:0] popa = '0;
   logic           popc = 1'b0;
   logic           popz = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   irq_ctl_unit #(.NUM_IRQ(N), .SYNC_STAGES(2), .PC_W(PCW)) uut (
      .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n),
      .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .irq_req_o(req), .src_id_o(src),
      .take_i(take), .next_pc_i(npc), .carry_i(cin), .zero_i(zin),
      .push_o(push), .push_addr_o(paddr), .push_carry_o(pc_o), .push_zero_o(pz_o),
      .vec_load_o(vload), .vector_o(vec),
      .iret_i(iret), .pop_o(pop), .pop_valid_i(popv), .pop_addr_i(popa),
      .pop_carry_i(popc), .pop_zero_i(popz),
      .restore_o(restore), .restore_addr_o(raddr),
      .restore_carry_o(rc_o), .restore_zero_o(rz_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wreg(input logic [1:0] s, input logic [7:0] d);
      sel = s; wdata = d; wr = 1'b1;
      step();
      wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] s, output logic [7:0] d);
      sel = s;
      #1;
      d = rdata;
   endtask

   task automatic pulse_lines(input logic [N-1:0] p);
      irq_n = ~p;
      step();
      irq_n = '1;
      step(); step(); step();
   endtask

   function automatic int lowest(input int v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return 0;
   endfunction

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      step(); step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      for (int i = 0; i < 3; i++) begin
         rreg(2'(i), d);
         check(d == 8'h00, "R1 reset register", d, 0);
      end
      check(req == 1'b0, "R1 reset request", req, 0);

      // R4 global enable index and bit 0
      wreg(2'd2, 8'hFF);
      rreg(2'd2, d);
      check(d == 8'h01, "R4 global enable read", d, 1);
      rreg(2'd3, d);
      check(d == 8'h00, "R4 index 3 reads zero", d, 0);
      wreg(2'd2, 8'h00);

      // R10 mask upper bits
      wreg(2'd1, 8'hFF);
      rreg(2'd1, d);
      check(d == 8'h3F, "R10 mask upper bits", d, 8'h3F);

      // R2 timing of pending capture
      irq_n = ~6'b000100;
      step(); // sampled at this edge
      irq_n = '1;
      step();
      rreg(2'd0, d);
      check(d == 8'h00, "R2 pending not yet set", d, 0);
      step();
      rreg(2'd0, d);
      check(d == 8'h04, "R2 pending set after sync", d, 4);
      step(); step();
      rreg(2'd0, d);
      check(d == 8'h04, "R2 pending sticky", d, 4);
      wreg(2'd0, 8'h3F);

      // R3, R6, R10 sweep over pending patterns
      wreg(2'd2, 8'h01);
      for (int p = 0; p < 64; p++) begin
         pulse_lines(6'(p));
         rreg(2'd0, d);
         check(d == 8'(p), "R2 pending pattern", d, p);
         wreg(2'd0, 8'h00);
         rreg(2'd0, d);
         check(d == 8'(p), "R3 write zero no effect", d, p);
         wreg(2'd0, 8'hC0);
         rreg(2'd0, d);
         check(d == 8'(p), "R10 pending upper bits ignored", d, p);
         rreg(2'd0, d);
         check(req == (p != 0), "R5 request with full mask", req, (p != 0));
         if (p != 0) check(src == 3'(lowest(p)), "R6 lowest source", src, lowest(p));
         wreg(2'd0, 8'(p) & 8'h15);
         rreg(2'd0, d);
         check(d == (8'(p) & 8'h2A), "R3 write one clears", d, p & 8'h2A);
         wreg(2'd0, 8'h3F);
      end

      // R5, R6 sweep over mask patterns with all pending
      pulse_lines(6'h3F);
      for (int m = 0; m < 64; m++) begin
         wreg(2'd1, 8'(m));
         wreg(2'd2, 8'h01);
         check(req == (m != 0), "R5 request follows mask", req, (m != 0));
         if (m != 0) check(src == 3'(lowest(m)), "R6 lowest masked source", src, lowest(m));
         wreg(2'd2, 8'h00);
         check(req == 1'b0, "R5 global enable overrides mask", req, 0);
      end

      // R3 re-set while line still low
      wreg(2'd0, 8'h3F);
      irq_n = ~6'b000010;
      step(); step(); step(); step();
      wreg(2'd0, 8'h02);
      rreg(2'd0, d);
      check(d[1] == 1'b0, "R3 cleared in write cycle", d[1], 0);
      step();
      rreg(2'd0, d);
      check(d[1] == 1'b1, "R3 re-set while line low", d[1], 1);
      irq_n = '1;
      step(); step(); step();
      wreg(2'd0, 8'h3F);

      // R7 take
      pulse_lines(6'b100000);
      wreg(2'd1, 8'h3F);
      wreg(2'd2, 8'h01);
      check(req == 1'b1 && src == 3'd5, "R6 single source five", src, 5);
      iret = 1'b1;
      #1;
      check(pop == 1'b0, "R9 return outside service ignored", pop, 0);
      iret = 1'b0;
      take = 1'b1; npc = 12'h123; cin = 1'b1; zin = 1'b0;
      #1;
      check(push == 1'b1 && vload == 1'b1, "R7 push and vector load", {push, vload}, 3);
      check(paddr == 12'h123, "R7 push address", paddr, 12'h123);
      check(pc_o == 1'b1 && pz_o == 1'b0, "R7 pushed flags", {pc_o, pz_o}, 2);
      check(vec == 12'h000, "R7 vector address", vec, 0);
      step();
      take = 1'b0;

      // R8 no nesting
      for (int k = 0; k < 4; k++) begin
         check(req == 1'b0, "R8 no request during service", req, 0);
         check(push == 1'b0, "R8 no second push", push, 0);
         step();
      end

      // R9 return handshake
      iret = 1'b1;
      #1;
      check(pop == 1'b1, "R9 pop on return", pop, 1);
      step();
      iret = 1'b0;
      check(req == 1'b0, "R8 no request while popping", req, 0);
      popv = 1'b1; popa = 12'h0AB; popc = 1'b0; popz = 1'b1;
      step();
      popv = 1'b0; popa = '0; popz = 1'b0;
      #1;
      check(restore == 1'b1, "R9 restore strobe", restore, 1);
      check(raddr == 12'h0AB, "R9 restore address", raddr, 12'h0AB);
      check(rc_o == 1'b0 && rz_o == 1'b1, "R9 restore flags", {rc_o, rz_o}, 1);
      check(req == 1'b1, "R8 request after return", req, 1);
      step();
      check(restore == 1'b0, "R9 restore single cycle", restore, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule